// File: doc/BRIEF.md
# Dual-Master Tightly Coupled Memory Crossbar

This block sits between a small RISC-V class core and its on-chip storage. It has two master ports: an instruction fetch port that only reads, and a load/store port that reads and writes with byte enables. It has three slave targets: an instruction SRAM, a data SRAM and a peripheral register window. Each incoming address is decoded into one of these targets, or into "unmapped". Each SRAM has its own small arbiter. The two masters therefore finish in the same cycle whenever they go to different targets, and the load/store port can still reach the instruction SRAM. That path is used to copy a program image in and to read constant tables.

The map is compact and code and data together use at most 32 KB. The instruction SRAM starts at address zero. The data SRAM starts at a parameterised, size-aligned base. The peripheral window is every address whose bits above the window width are all ones, so the registers can be reached with a negative 12-bit offset from register zero. The addresses sent to the slaves are narrowed to word indices of the memory size. Every slave answers with a fixed one-cycle read latency. A registered target tag sends each response back to the port that issued it.

Top module: `hxb_crossbar`

## Requirements
- R1: While reset is applied, and in idle cycles after it, `fch_ack`, `lsu_ack`, `imem_en`, `dmem_en` and `per_en` are all 0.
- R2: A fetch to one SRAM and a load/store access to the other SRAM in the same cycle are both accepted. `lsu_ready` is 1 and both ports see `*_ack` one cycle later with the correct read data.
- R3: A load/store write into the instruction SRAM region (address below `IMEM_BYTES`) stores the data, and a later fetch of that address returns it.
- R4: A load/store read of the instruction SRAM region returns the stored word, with `lsu_err` at 0.
- R5: When both ports claim the same SRAM in one cycle, the fetch port is served and `lsu_ready` is 0 in that cycle, so the load/store request is not accepted. When the load/store request is repeated without a competing fetch, it is accepted.
- R6: Any load/store address whose bits above `PERIPH_BITS` are all ones goes to the peripheral target, with `per_addr` equal to address bits [PERIPH_BITS-1:2]. Reads return `per_rdata` and writes drive `per_we`/`per_wdata`.
- R7: An address that is in no region is accepted, and one cycle later it produces `*_ack`=1, `*_err`=1 and `*_rdata`=0. No slave enable is raised for it.
- R8: A request on the fetch port with `fch_we`=1 raises no slave enable. It is answered with `fch_err`=1 and leaves memory contents unchanged.
- R9: `lsu_be` (bit n covers data byte n) is passed unchanged to the selected SRAM, so byte and halfword stores change only the enabled bytes.
- R10: Every accepted access produces exactly one `*_ack` pulse, on the port that issued it, exactly one cycle after acceptance. The other port sees no acknowledgement.
- R11: The fetch port may read the data SRAM. A fetch aimed at the peripheral window is answered as an error.
- R12: `imem_addr` and `dmem_addr` carry word indices that are log2(size)-2 bits wide, taken from address bits [log2(size)-1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fch_req | input | 1 | Fetch request |
| fch_we | input | 1 | Fetch write attempt (illegal) |
| fch_addr | input | ADDR_W | Fetch byte address |
| fch_ack | output | 1 | Fetch response valid |
| fch_err | output | 1 | Fetch response is an error |
| fch_rdata | output | DATA_W | Fetch read data |
| lsu_req | input | 1 | Load/store request |
| lsu_we | input | 1 | Load/store write |
| lsu_be | input | DATA_W/8 | Load/store byte enables |
| lsu_addr | input | ADDR_W | Load/store byte address |
| lsu_wdata | input | DATA_W | Load/store write data |
| lsu_ready | output | 1 | Load/store request accepted this cycle |
| lsu_ack | output | 1 | Load/store response valid |
| lsu_err | output | 1 | Load/store response is an error |
| lsu_rdata | output | DATA_W | Load/store read data |
| imem_en | output | 1 | Instruction SRAM enable |
| imem_we | output | 1 | Instruction SRAM write |
| imem_be | output | DATA_W/8 | Instruction SRAM byte enables |
| imem_addr | output | log2(IMEM_BYTES)-2 | Instruction SRAM word index |
| imem_wdata | output | DATA_W | Instruction SRAM write data |
| imem_rdata | input | DATA_W | Instruction SRAM read data, one cycle after enable |
| dmem_en | output | 1 | Data SRAM enable |
| dmem_we | output | 1 | Data SRAM write |
| dmem_be | output | DATA_W/8 | Data SRAM byte enables |
| dmem_addr | output | log2(DMEM_BYTES)-2 | Data SRAM word index |
| dmem_wdata | output | DATA_W | Data SRAM write data |
| dmem_rdata | input | DATA_W | Data SRAM read data, one cycle after enable |
| per_en | output | 1 | Peripheral window enable |
| per_we | output | 1 | Peripheral write |
| per_be | output | DATA_W/8 | Peripheral byte enables |
| per_addr | output | PERIPH_BITS-2 | Peripheral word index within the window |
| per_wdata | output | DATA_W | Peripheral write data |
| per_rdata | input | DATA_W | Peripheral read data, one cycle after enable |

## Verification
The bench builds the block with both SRAMs shrunk to 4 KB, the data SRAM based at 0x4000 and a 12-bit peripheral window. With these values the map has holes between the instruction and data regions, above the data region and just below the window. That puts unmapped errors at 0x2000, 0x5000 and 0xFFFF_E000 within reach of the tests, next to legal accesses to both SRAMs. The smaller SRAMs also give 10-bit word indices, so the narrowed address slicing is checked at a width other than the default.

// File: rtl/hxb_pkg.sv
package hxb_pkg;

  // Decoded destination of one master request
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_IMEM   = 2'd1,
    TGT_DMEM   = 2'd2,
    TGT_PERIPH = 2'd3
  } tgt_e;

endpackage

// File: rtl/hxb_rst_sync.sv
module hxb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hxb_decode.sv
module hxb_decode
  import hxb_pkg::*;
#(
  parameter int              ADDR_W      = 32,
  parameter int              IMEM_BYTES  = 16384,
  parameter int              DMEM_BYTES  = 16384,
  parameter logic [ADDR_W-1:0] DMEM_BASE = 'h4000,
  parameter int              PERIPH_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);

  localparam int IMEM_LSB = $clog2(IMEM_BYTES);
  localparam int DMEM_LSB = $clog2(DMEM_BYTES);
  localparam logic [ADDR_W-DMEM_LSB-1:0] DMEM_TAG = DMEM_BASE[ADDR_W-1:DMEM_LSB];

  logic imem_hit;
  logic dmem_hit;
  logic per_hit;

  always_comb begin
    imem_hit = (addr[ADDR_W-1:IMEM_LSB] == '0);
    dmem_hit = (addr[ADDR_W-1:DMEM_LSB] == DMEM_TAG);
    per_hit  = &addr[ADDR_W-1:PERIPH_BITS];
    if (per_hit) begin
      tgt = TGT_PERIPH;
    end else if (imem_hit) begin
      tgt = TGT_IMEM;
    end else if (dmem_hit) begin
      tgt = TGT_DMEM;
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/hxb_sram_port.sv
module hxb_sram_port #(
  parameter int WA     = 12,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fch_claim,
  input  logic [WA-1:0]     fch_waddr,
  input  logic              lsu_claim,
  input  logic              lsu_we,
  input  logic [BE_W-1:0]   lsu_be,
  input  logic [WA-1:0]     lsu_waddr,
  input  logic [DATA_W-1:0] lsu_wdata,
  output logic              lsu_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [WA-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  // Fixed priority: instruction fetch first, load/store waits
  always_comb begin
    lsu_gnt   = lsu_claim && !fch_claim;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (fch_claim) begin
      mem_en   = 1'b1;
      mem_be   = '1;
      mem_addr = fch_waddr;
    end else if (lsu_claim) begin
      mem_en    = 1'b1;
      mem_we    = lsu_we;
      mem_be    = lsu_be;
      mem_addr  = lsu_waddr;
      mem_wdata = lsu_wdata;
    end
  end

  AST_FETCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fch_claim && lsu_claim) |-> (!lsu_gnt && mem_en && !mem_we && mem_addr == fch_waddr)); // R5

endmodule

// File: rtl/hxb_resp.sv
module hxb_resp
  import hxb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  tgt_e              tgt,
  input  logic              is_read,
  input  logic [DATA_W-1:0] imem_rdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              ack,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);

  logic tag_vld_q, tag_vld_d;
  tgt_e tag_tgt_q, tag_tgt_d;
  logic tag_rd_q,  tag_rd_d;
  logic tag_en;

  // Next-state
  always_comb begin
    tag_en    = accept || tag_vld_q;
    tag_vld_d = accept;
    tag_tgt_d = accept ? tgt : TGT_NONE;
    tag_rd_d  = accept && is_read;
  end

  // Registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_vld_q <= 1'b0;
      tag_tgt_q <= TGT_NONE;
      tag_rd_q  <= 1'b0;
    end else if (tag_en) begin
      tag_vld_q <= tag_vld_d;
      tag_tgt_q <= tag_tgt_d;
      tag_rd_q  <= tag_rd_d;
    end
  end

  // Response steering
  always_comb begin
    ack   = tag_vld_q;
    err   = tag_vld_q && (tag_tgt_q == TGT_NONE);
    rdata = '0;
    if (tag_vld_q && tag_rd_q) begin
      case (tag_tgt_q)
        TGT_IMEM:   rdata = imem_rdata;
        TGT_DMEM:   rdata = dmem_rdata;
        TGT_PERIPH: rdata = per_rdata;
        default:    rdata = '0;
      endcase
    end
  end

  AST_ACK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ack); // R10
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !accept) |=> !ack); // R10
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err) |-> (rdata == '0)); // R7

endmodule

// File: rtl/hxb_crossbar.sv
module hxb_crossbar
  import hxb_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                IMEM_BYTES  = 16384,
  parameter int                DMEM_BYTES  = 16384,
  parameter logic [ADDR_W-1:0] DMEM_BASE   = 'h4000,
  parameter int                PERIPH_BITS = 12,
  localparam int               BE_W        = DATA_W / 8,
  localparam int               IMEM_WA     = $clog2(IMEM_BYTES) - 2,
  localparam int               DMEM_WA     = $clog2(DMEM_BYTES) - 2,
  localparam int               PER_WA      = PERIPH_BITS - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fch_req,
  input  logic               fch_we,
  input  logic [ADDR_W-1:0]  fch_addr,
  output logic               fch_ack,
  output logic               fch_err,
  output logic [DATA_W-1:0]  fch_rdata,
  input  logic               lsu_req,
  input  logic               lsu_we,
  input  logic [BE_W-1:0]    lsu_be,
  input  logic [ADDR_W-1:0]  lsu_addr,
  input  logic [DATA_W-1:0]  lsu_wdata,
  output logic               lsu_ready,
  output logic               lsu_ack,
  output logic               lsu_err,
  output logic [DATA_W-1:0]  lsu_rdata,
  output logic               imem_en,
  output logic               imem_we,
  output logic [BE_W-1:0]    imem_be,
  output logic [IMEM_WA-1:0] imem_addr,
  output logic [DATA_W-1:0]  imem_wdata,
  input  logic [DATA_W-1:0]  imem_rdata,
  output logic               dmem_en,
  output logic               dmem_we,
  output logic [BE_W-1:0]    dmem_be,
  output logic [DMEM_WA-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               per_en,
  output logic               per_we,
  output logic [BE_W-1:0]    per_be,
  output logic [PER_WA-1:0]  per_addr,
  output logic [DATA_W-1:0]  per_wdata,
  input  logic [DATA_W-1:0]  per_rdata
);

  localparam int NPORT    = 2;
  localparam int IMEM_LSB = IMEM_WA + 2;
  localparam int DMEM_LSB = DMEM_WA + 2;

  logic rst_sync_n;

  hxb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Address decode, one decoder per master
  logic [ADDR_W-1:0] port_addr [NPORT];
  tgt_e              port_tgt  [NPORT];

  assign port_addr[0] = fch_addr;
  assign port_addr[1] = lsu_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    hxb_decode #(
      .ADDR_W      (ADDR_W),
      .IMEM_BYTES  (IMEM_BYTES),
      .DMEM_BYTES  (DMEM_BYTES),
      .DMEM_BASE   (DMEM_BASE),
      .PERIPH_BITS (PERIPH_BITS)
    ) u_dec (
      .addr (port_addr[p]),
      .tgt  (port_tgt[p])
    );
  end

  // Fetch is read-only and cannot reach the peripheral window
  tgt_e fch_tgt;
  tgt_e lsu_tgt;
  logic fch_imem, fch_dmem;
  logic lsu_imem, lsu_dmem, lsu_per;
  logic imem_lsu_gnt, dmem_lsu_gnt;
  logic lsu_accept;

  always_comb begin
    fch_tgt  = (fch_we || port_tgt[0] == TGT_PERIPH) ? TGT_NONE : port_tgt[0];
    lsu_tgt  = port_tgt[1];
    fch_imem = fch_req && (fch_tgt == TGT_IMEM);
    fch_dmem = fch_req && (fch_tgt == TGT_DMEM);
    lsu_imem = lsu_req && (lsu_tgt == TGT_IMEM);
    lsu_dmem = lsu_req && (lsu_tgt == TGT_DMEM);
    lsu_per  = lsu_req && (lsu_tgt == TGT_PERIPH);
  end

  hxb_sram_port #(.WA(IMEM_WA), .DATA_W(DATA_W), .BE_W(BE_W)) u_iport (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fch_claim (fch_imem),
    .fch_waddr (fch_addr[IMEM_LSB-1:2]),
    .lsu_claim (lsu_imem),
    .lsu_we    (lsu_we),
    .lsu_be    (lsu_be),
    .lsu_waddr (lsu_addr[IMEM_LSB-1:2]),
    .lsu_wdata (lsu_wdata),
    .lsu_gnt   (imem_lsu_gnt),
    .mem_en    (imem_en),
    .mem_we    (imem_we),
    .mem_be    (imem_be),
    .mem_addr  (imem_addr),
    .mem_wdata (imem_wdata)
  );

  hxb_sram_port #(.WA(DMEM_WA), .DATA_W(DATA_W), .BE_W(BE_W)) u_dport (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fch_claim (fch_dmem),
    .fch_waddr (fch_addr[DMEM_LSB-1:2]),
    .lsu_claim (lsu_dmem),
    .lsu_we    (lsu_we),
    .lsu_be    (lsu_be),
    .lsu_waddr (lsu_addr[DMEM_LSB-1:2]),
    .lsu_wdata (lsu_wdata),
    .lsu_gnt   (dmem_lsu_gnt),
    .mem_en    (dmem_en),
    .mem_we    (dmem_we),
    .mem_be    (dmem_be),
    .mem_addr  (dmem_addr),
    .mem_wdata (dmem_wdata)
  );

  // Peripheral window is only reachable from the load/store port
  always_comb begin
    per_en    = lsu_per;
    per_we    = lsu_per && lsu_we;
    per_be    = lsu_per ? lsu_be : '0;
    per_addr  = lsu_addr[PERIPH_BITS-1:2];
    per_wdata = lsu_per ? lsu_wdata : '0;
  end

  always_comb begin
    lsu_ready  = !((lsu_imem && !imem_lsu_gnt) || (lsu_dmem && !dmem_lsu_gnt));
    lsu_accept = lsu_req && lsu_ready;
  end

  hxb_resp #(.DATA_W(DATA_W)) u_fresp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (fch_req),
    .tgt        (fch_tgt),
    .is_read    (!fch_we),
    .imem_rdata (imem_rdata),
    .dmem_rdata (dmem_rdata),
    .per_rdata  (per_rdata),
    .ack        (fch_ack),
    .err        (fch_err),
    .rdata      (fch_rdata)
  );

  hxb_resp #(.DATA_W(DATA_W)) u_lresp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (lsu_accept),
    .tgt        (lsu_tgt),
    .is_read    (!lsu_we),
    .imem_rdata (imem_rdata),
    .dmem_rdata (dmem_rdata),
    .per_rdata  (per_rdata),
    .ack        (lsu_ack),
    .err        (lsu_err),
    .rdata      (lsu_rdata)
  );

  AST_LSU_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lsu_req && !lsu_ready) |-> (fch_req && !fch_we)); // R5
  AST_PERIPH_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    per_en |-> (&lsu_addr[ADDR_W-1:PERIPH_BITS])); // R6
  AST_NO_FETCH_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (imem_we || dmem_we) |-> (lsu_req && lsu_we)); // R8

endmodule

// File: tb/tb_hxb_crossbar.sv
module tb_hxb_crossbar;

  localparam int IMEM_BYTES = 4096;
  localparam int DMEM_BYTES = 4096;
  localparam int IWA = $clog2(IMEM_BYTES) - 2;
  localparam int DWA = $clog2(DMEM_BYTES) - 2;
  localparam int PWA = 10;

  logic clk, rst_n;
  logic fch_req, fch_we;
  logic [31:0] fch_addr;
  logic fch_ack, fch_err;
  logic [31:0] fch_rdata;
  logic lsu_req, lsu_we;
  logic [3:0] lsu_be;
  logic [31:0] lsu_addr, lsu_wdata;
  logic lsu_ready, lsu_ack, lsu_err;
  logic [31:0] lsu_rdata;
  logic imem_en, imem_we;
  logic [3:0] imem_be;
  logic [IWA-1:0] imem_addr;
  logic [31:0] imem_wdata, imem_rdata;
  logic dmem_en, dmem_we;
  logic [3:0] dmem_be;
  logic [DWA-1:0] dmem_addr;
  logic [31:0] dmem_wdata, dmem_rdata;
  logic per_en, per_we;
  logic [3:0] per_be;
  logic [PWA-1:0] per_addr;
  logic [31:0] per_wdata, per_rdata;

  hxb_crossbar #(
    .ADDR_W(32), .DATA_W(32), .IMEM_BYTES(IMEM_BYTES), .DMEM_BYTES(DMEM_BYTES),
    .DMEM_BASE(32'h4000), .PERIPH_BITS(12)
  ) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Slave models: registered read, read-first, byte-enabled writes
  logic [31:0] imem [1 << IWA];
  logic [31:0] dmem [1 << DWA];
  logic [31:0] pmem [1 << PWA];

  always @(posedge clk) begin
    if (imem_en) begin
      for (int b = 0; b < 4; b++) if (imem_we && imem_be[b]) imem[imem_addr][8*b +: 8] <= imem_wdata[8*b +: 8];
      imem_rdata <= imem[imem_addr];
    end
    if (dmem_en) begin
      for (int b = 0; b < 4; b++) if (dmem_we && dmem_be[b]) dmem[dmem_addr][8*b +: 8] <= dmem_wdata[8*b +: 8];
      dmem_rdata <= dmem[dmem_addr];
    end
    if (per_en) begin
      for (int b = 0; b < 4; b++) if (per_we && per_be[b]) pmem[per_addr][8*b +: 8] <= per_wdata[8*b +: 8];
      per_rdata <= pmem[per_addr];
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Values seen while a request is driven, and the response one cycle later
  logic s_rdy, s_ien, s_den, s_pen;
  logic [IWA-1:0] s_iaddr;
  logic [DWA-1:0] s_daddr;
  logic [PWA-1:0] s_paddr;
  logic r_fack, r_ferr, r_lack, r_lerr;
  logic [31:0] r_fdata, r_ldata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic fw, input logic [31:0] fa,
                      input logic lr, input logic lw, input logic [3:0] lb,
                      input logic [31:0] la, input logic [31:0] ld);
    @(negedge clk);
    fch_req = fr; fch_we = fw; fch_addr = fa;
    lsu_req = lr; lsu_we = lw; lsu_be = lb; lsu_addr = la; lsu_wdata = ld;
    #1;
    s_rdy = lsu_ready; s_ien = imem_en; s_den = dmem_en; s_pen = per_en;
    s_iaddr = imem_addr; s_daddr = dmem_addr; s_paddr = per_addr;
    @(negedge clk);
    r_fack = fch_ack; r_ferr = fch_err; r_fdata = fch_rdata;
    r_lack = lsu_ack; r_lerr = lsu_err; r_ldata = lsu_rdata;
    fch_req = 1'b0; fch_we = 1'b0; lsu_req = 1'b0; lsu_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(!fch_ack && !lsu_ack, "R1 acks in reset", {30'd0, fch_ack, lsu_ack}, 32'd0);
    chk(!imem_en && !dmem_en && !per_en, "R1 enables idle", {29'd0, imem_en, dmem_en, per_en}, 32'd0);
  endtask

  task automatic t_parallel();
    step(1, 0, 32'h0000_0010, 1, 0, 4'hF, 32'h0000_4020, 0);
    chk(s_rdy === 1'b1, "R2 lsu_ready", {31'd0, s_rdy}, 32'd1);
    chk(r_fack && !r_ferr && r_fdata == 32'hA000_0004, "R2 fetch data", r_fdata, 32'hA000_0004);
    chk(r_lack && !r_lerr && r_ldata == 32'hD000_0008, "R2 lsu data", r_ldata, 32'hD000_0008);
    chk(s_iaddr == IWA'(4), "R12 imem word index", 32'(s_iaddr), 32'd4);
    chk(s_daddr == DWA'(8), "R12 dmem word index", 32'(s_daddr), 32'd8);
    @(negedge clk);
    chk(!fch_ack && !lsu_ack, "R10 single ack pulse", {30'd0, fch_ack, lsu_ack}, 32'd0);
  endtask

  task automatic t_fetch_dmem_lsu_imem();
    step(1, 0, 32'h0000_4008, 1, 0, 4'hF, 32'h0000_0100, 0);
    chk(r_fack && !r_ferr && r_fdata == 32'hD000_0002, "R11 fetch from dmem", r_fdata, 32'hD000_0002);
    chk(r_lack && !r_lerr && r_ldata == 32'hA000_0040, "R4 lsu reads imem", r_ldata, 32'hA000_0040);
  endtask

  task automatic t_boot_write();
    step(0, 0, 0, 1, 1, 4'hF, 32'h0000_0200, 32'h1234_5678);
    chk(r_lack && !r_lerr, "R3 write ack", {30'd0, r_lack, r_lerr}, 32'd2);
    step(1, 0, 32'h0000_0200, 0, 0, 4'h0, 0, 0);
    chk(r_fdata == 32'h1234_5678, "R3 fetch sees written code", r_fdata, 32'h1234_5678);
  endtask

  task automatic t_bytes();
    step(0, 0, 0, 1, 1, 4'b0001, 32'h0000_4040, 32'h0000_00EF);
    step(0, 0, 0, 1, 1, 4'b1100, 32'h0000_4040, 32'hBEEF_0000);
    step(0, 0, 0, 1, 0, 4'hF, 32'h0000_4040, 0);
    chk(r_ldata == 32'hBEEF_00EF, "R9 byte and halfword store", r_ldata, 32'hBEEF_00EF);
  endtask

  task automatic t_clash();
    step(1, 0, 32'h0000_0020, 1, 0, 4'hF, 32'h0000_0024, 0);
    chk(s_rdy === 1'b0, "R5 lsu stalled on imem", {31'd0, s_rdy}, 32'd0);
    chk(r_fdata == 32'hA000_0008 && r_fack, "R5 fetch wins imem", r_fdata, 32'hA000_0008);
    chk(!r_lack, "R5 no lsu ack when stalled", {31'd0, r_lack}, 32'd0);
    step(0, 0, 0, 1, 0, 4'hF, 32'h0000_0024, 0);
    chk(s_rdy && r_lack && r_ldata == 32'hA000_0009, "R5 retried lsu served", r_ldata, 32'hA000_0009);
    step(1, 0, 32'h0000_4000, 1, 0, 4'hF, 32'h0000_4004, 0);
    chk(s_rdy === 1'b0 && r_fdata == 32'hD000_0000, "R5 fetch wins dmem", r_fdata, 32'hD000_0000);
  endtask

  task automatic t_periph();
    step(0, 0, 0, 1, 0, 4'hF, 32'hFFFF_F008, 0);
    chk(s_pen && s_paddr == PWA'(2), "R6 window index", 32'(s_paddr), 32'd2);
    chk(r_lack && !r_lerr && r_ldata == 32'hC000_0002, "R6 periph read", r_ldata, 32'hC000_0002);
    step(0, 0, 0, 1, 1, 4'hF, 32'hFFFF_FFFC, 32'h5A5A_5A5A);
    step(0, 0, 0, 1, 0, 4'hF, 32'hFFFF_FFFC, 0);
    chk(s_paddr == PWA'(1023) && r_ldata == 32'h5A5A_5A5A, "R6 top register", r_ldata, 32'h5A5A_5A5A);
  endtask

  task automatic t_unmapped();
    logic [31:0] holes [3] = '{32'h0000_2000, 32'h0000_5000, 32'hFFFF_E000};
    foreach (holes[i]) begin
      step(0, 0, 0, 1, 0, 4'hF, holes[i], 0);
      chk(s_rdy && !s_ien && !s_den && !s_pen, "R7 no slave enable", holes[i], 32'd0);
      chk(r_lack && r_lerr && r_ldata == 32'd0, "R7 error response", r_ldata, 32'd0);
    end
    step(1, 0, 32'h0000_8000, 0, 0, 4'h0, 0, 0);
    chk(r_fack && r_ferr && r_fdata == 0 && !r_lack, "R7 fetch unmapped", r_fdata, 32'd0);
  endtask

  task automatic t_fetch_write();
    step(1, 1, 32'h0000_0300, 0, 0, 4'h0, 0, 0);
    chk(!s_ien && !s_den && !s_pen, "R8 fetch write no enable", {29'd0, s_ien, s_den, s_pen}, 32'd0);
    chk(r_fack && r_ferr, "R8 fetch write error", {30'd0, r_fack, r_ferr}, 32'd3);
    step(0, 0, 0, 1, 0, 4'hF, 32'h0000_0300, 0);
    chk(r_ldata == 32'hA000_00C0, "R8 memory unchanged", r_ldata, 32'hA000_00C0);
    step(1, 0, 32'hFFFF_F000, 0, 0, 4'h0, 0, 0);
    chk(r_fack && r_ferr && !s_pen, "R11 fetch to periph errors", r_fdata, 32'd0);
  endtask

  task automatic t_routing();
    step(0, 0, 0, 1, 0, 4'hF, 32'h0000_4010, 0);
    chk(r_lack && !r_fack, "R10 lsu-only response", {30'd0, r_fack, r_lack}, 32'd1);
    step(1, 0, 32'h0000_0014, 0, 0, 4'h0, 0, 0);
    chk(r_fack && !r_lack && r_fdata == 32'hA000_0005, "R10 fetch-only response", r_fdata, 32'hA000_0005);
  endtask

  initial begin
    for (int i = 0; i < (1 << IWA); i++) imem[i] = 32'hA000_0000 | i;
    for (int i = 0; i < (1 << DWA); i++) dmem[i] = 32'hD000_0000 | i;
    for (int i = 0; i < (1 << PWA); i++) pmem[i] = 32'hC000_0000 | i;
    rst_n = 1'b0;
    fch_req = 0; fch_we = 0; fch_addr = 0;
    lsu_req = 0; lsu_we = 0; lsu_be = 0; lsu_addr = 0; lsu_wdata = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_parallel();
    t_fetch_dmem_lsu_imem();
    t_boot_write();
    t_bytes();
    t_clash();
    t_periph();
    t_unmapped();
    t_fetch_write();
    t_routing();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule